// File: doc/BRIEF.md
# Segmented Event Ring Producer

This block fills a circular event queue in system memory on behalf of a hardware agent. The queue lives in several segments of different lengths. A small segment table in memory lists every segment's base address and its slot count. Each accepted event becomes a 16-byte record at the current enqueue position. The consumer learns that a slot is valid by watching a single ownership bit in the record. The producer flips the meaning of that bit each time it completes a lap of all segments.

Software sets three values: the number of table entries, the table's base address, and the consumer's dequeue pointer. The block fetches table entries by itself through a one-beat request/ready memory port. It accepts events with a valid/ready handshake and answers each one with a one-cycle done pulse that carries a status code. It also shows the ring's empty, full and unconfigured conditions at all times, together with the enqueue pointer and the current ownership value.

Top module: `evq_producer`

## Requirements
- R1: After reset the ownership value (`cycle_state`) is 1, `enq_ptr` is 0, `busy` and `ev_done` are low, and the ring reports unconfigured.
- R2: The ring is unconfigured while the table size is 0, the table base is 0 or the enqueue pointer is 0. An event offered in that state finishes with status 2 and causes no memory transaction.
- R3: An accepted event is written in two transactions to the enqueue address. The first is a full-strobe write (`mem_wstrb` = 16'hFFFF) with record bit 96 (bit 0 of byte 12) set to the inverse of `cycle_state`. The second is issued only after the first has been acknowledged. It is a write with `mem_wstrb` = 16'hF000 and bit 96 equal to `cycle_state`. All other record bits come from `ev_data`.
- R4: After each event write the enqueue pointer advances by 16 and the remaining slot count of the segment drops by one.
- R5: When the remaining count reaches 0, the segment index increments and the block reads table entry i from table base + 16*i. That entry supplies the new enqueue pointer (bits 63:0 of the 16-byte entry, truncated to the address width) and the slot count (bits 79:64).
- R6: When the incremented index equals the table size, the index returns to 0 and `cycle_state` inverts.
- R7: `ring_empty` is high exactly when the enqueue pointer equals the dequeue pointer.
- R8: `ring_full` is high when one free slot remains. If the segment has exactly one slot left, this means the dequeue pointer equals the base of the next segment (index + 1, modulo the table size). Otherwise it means the dequeue pointer equals the enqueue pointer + 16.
- R9: An event offered to a configured but full ring finishes with status 1 and causes no memory transaction.
- R10: A write to the table size or the table base reloads the enqueue pointer and count from the entry at the current index, provided both values are then nonzero. Otherwise nothing is fetched.
- R11: A successful event finishes with a one-cycle `ev_done` and status 0. `busy` is high from acceptance until the second write and any following table reads are complete.
- R12: A reload whose current index is greater than the table size sets `acc_err`, performs no memory transaction, and leaves the enqueue pointer unchanged. A later successful table read clears `acc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_size_we | input | 1 | Write strobe for the table size |
| cfg_size | input | 16 | Number of segment-table entries |
| cfg_base_we | input | 1 | Write strobe for the table base |
| cfg_base | input | ADDR_W | Segment table byte address |
| cfg_deq_we | input | 1 | Write strobe for the dequeue pointer |
| cfg_deq | input | ADDR_W | Consumer dequeue pointer |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_data | input | 128 | Event record (bit 96 is replaced) |
| ev_done | output | 1 | One-cycle completion pulse |
| ev_status | output | 2 | 0 ok, 1 full, 2 unconfigured |
| busy | output | 1 | Event or table fetch in progress |
| ring_empty | output | 1 | Enqueue pointer equals dequeue pointer |
| ring_full | output | 1 | One free slot left |
| ring_uninit | output | 1 | Ring not configured |
| enq_ptr | output | ADDR_W | Current enqueue pointer |
| cycle_state | output | 1 | Producer ownership value |
| acc_err | output | 1 | Table index beyond table size |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address, 16-byte aligned |
| mem_wdata | output | 128 | Write data |
| mem_wstrb | output | 16 | Byte write enables |
| mem_ready | input | 1 | Request completes this cycle |
| mem_rdata | input | 128 | Read data, valid with mem_ready |

## Verification
The bench walks a three-segment ring to the last usable slot. A design that tested fullness only against enqueue + 16 would accept the ninth event and overwrite the consumer's slot across the wrap. After the lap it checks that the next record carries an ownership bit of 0. A design that never toggled would make stale records look fresh. A memory monitor checks that every final-dword write follows a full write of the same slot with the opposite bit. A design that wrote the bit first would expose half-written records. Events offered while unconfigured or full, and a reload whose index exceeds the table size, must produce no memory transaction at all.

// File: rtl/evq_pkg.sv
// Shared constants and types for the event ring producer.
package evq_pkg;
    localparam int REC_W     = 128;  // one record is 16 bytes
    localparam int REC_BYTES = REC_W / 8;
    localparam int OWN_BIT   = 96;   // bit 0 of byte 12
    localparam int ENT_CNT_LSB = 64; // slot count field inside a table entry

    typedef enum logic [1:0] {
        EVS_OK     = 2'd0,
        EVS_FULL   = 2'd1,
        EVS_UNINIT = 2'd2
    } evq_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_REC,
        S_WR_OWN,
        S_RD_CUR,
        S_RD_NXT
    } evq_state_e;
endpackage

// File: rtl/evq_occupancy.sv
// Empty/full decision for the ring.
// Assumes nxt_base holds the base of the segment after the current one.
module evq_occupancy #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] enq,
    input  logic [ADDR_W-1:0] deq,
    input  logic [ADDR_W-1:0] nxt_base,
    input  logic [CNT_W-1:0]  left,
    output logic              empty,
    output logic              full
);
    import evq_pkg::*;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(REC_BYTES);

    // Compare the dequeue pointer with the slot after the next write.
    always_comb begin
        empty = (enq == deq);
        if (left == CNT_W'(1)) full = (deq == nxt_base);
        else                   full = (deq == enq + STEP);
    end
endmodule

// File: rtl/evq_entry_decode.sv
// Splits a 16-byte segment-table entry into base and slot count.
// Assumes the base is at bits 63:0 and the count at bits 79:64.
module evq_entry_decode #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [evq_pkg::REC_W-1:0] rdata,
    output logic [ADDR_W-1:0]         seg_base,
    output logic [CNT_W-1:0]          seg_cnt
);
    import evq_pkg::*;
    logic unused_hi;

    // Field extraction; the remaining bits are reserved.
    always_comb begin
        seg_base  = rdata[ADDR_W-1:0];
        seg_cnt   = rdata[ENT_CNT_LSB +: CNT_W];
        unused_hi = ^{rdata[REC_W-1:ENT_CNT_LSB+CNT_W], rdata[ENT_CNT_LSB-1:ADDR_W]};
    end
endmodule

// File: rtl/evq_rec_pack.sv
// Builds the write beat for either phase of an event write.
// Phase 0 writes all bytes with the ownership bit inverted; phase 1 only the last dword.
module evq_rec_pack (
    input  logic [evq_pkg::REC_W-1:0]     rec,
    input  logic                          own,
    input  logic                          final_phase,
    output logic [evq_pkg::REC_W-1:0]     wdata,
    output logic [evq_pkg::REC_BYTES-1:0] wstrb
);
    import evq_pkg::*;

    // Substitute the ownership bit and select the byte enables.
    always_comb begin
        wdata          = rec;
        wdata[OWN_BIT] = final_phase ? own : ~own;
        wstrb          = final_phase ? 16'hF000 : 16'hFFFF;
    end
endmodule

// File: rtl/evq_producer.sv
// Producer of a segmented event ring in system memory.
// Fetches segment entries, writes records in two phases, tracks ownership
// and occupancy. Assumes a 16-byte-aligned table and segments and a memory
// port that holds one transaction until mem_ready.
module evq_producer #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_size_we,
    input  logic [IDX_W-1:0]      cfg_size,
    input  logic                  cfg_base_we,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic                  cfg_deq_we,
    input  logic [ADDR_W-1:0]     cfg_deq,
    input  logic                  ev_valid,
    output logic                  ev_ready,
    input  logic [127:0]          ev_data,
    output logic                  ev_done,
    output logic [1:0]            ev_status,
    output logic                  busy,
    output logic                  ring_empty,
    output logic                  ring_full,
    output logic                  ring_uninit,
    output logic [ADDR_W-1:0]     enq_ptr,
    output logic                  cycle_state,
    output logic                  acc_err,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [127:0]          mem_wdata,
    output logic [15:0]           mem_wstrb,
    input  logic                  mem_ready,
    input  logic [127:0]          mem_rdata
);
    import evq_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(REC_BYTES);

    evq_state_e          state_q;
    logic [REC_W-1:0]    rec_q;
    logic [ADDR_W-1:0]   enq_q, nxt_q, tbase_q, deq_q;
    logic [CNT_W-1:0]    left_q;
    logic [IDX_W-1:0]    idx_q, size_q, nxt_idx, fetch_idx, idx_inc;
    logic                own_q, pend_q, evt_q, err_q, done_q;
    logic [1:0]          status_q;
    logic [ADDR_W-1:0]   seg_base;
    logic [CNT_W-1:0]    seg_cnt;
    logic                occ_empty, occ_full, uninit;
    logic [IDX_W-1:0]    new_size;
    logic [ADDR_W-1:0]   new_base;

    evq_occupancy #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_occ (
        .enq(enq_q), .deq(deq_q), .nxt_base(nxt_q), .left(left_q),
        .empty(occ_empty), .full(occ_full)
    );

    evq_entry_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
        .rdata(mem_rdata), .seg_base(seg_base), .seg_cnt(seg_cnt)
    );

    evq_rec_pack u_pack (
        .rec(rec_q), .own(own_q), .final_phase(state_q == S_WR_OWN),
        .wdata(mem_wdata), .wstrb(mem_wstrb)
    );

    // Index arithmetic and memory request formation.
    always_comb begin
        idx_inc   = idx_q + IDX_W'(1);
        nxt_idx   = (idx_inc == size_q) ? '0 : idx_inc;
        fetch_idx = (state_q == S_RD_NXT) ? nxt_idx : idx_q;
        uninit    = (size_q == '0) || (tbase_q == '0) || (enq_q == '0);
        new_size  = cfg_size_we ? cfg_size : size_q;
        new_base  = cfg_base_we ? cfg_base : tbase_q;
        mem_req   = (state_q != S_IDLE);
        mem_we    = (state_q == S_WR_REC) || (state_q == S_WR_OWN);
        mem_addr  = mem_we ? enq_q : tbase_q + (ADDR_W'(fetch_idx) << 4);
    end

    assign ev_ready    = (state_q == S_IDLE) && !pend_q;
    assign ev_done     = done_q;
    assign ev_status   = status_q;
    assign busy        = (state_q != S_IDLE);
    assign ring_empty  = occ_empty;
    assign ring_full   = occ_full;
    assign ring_uninit = uninit;
    assign enq_ptr     = enq_q;
    assign cycle_state = own_q;
    assign acc_err     = err_q;

    // Sequencer: event writes, pointer advance, segment change and table reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            rec_q    <= '0;
            enq_q    <= '0;
            nxt_q    <= '0;
            left_q   <= '0;
            idx_q    <= '0;
            own_q    <= 1'b1;
            pend_q   <= 1'b0;
            evt_q    <= 1'b0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
            status_q <= EVS_OK;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (pend_q) begin
                        pend_q <= 1'b0;
                        evt_q  <= 1'b0;
                        if (idx_q > size_q) err_q   <= 1'b1;
                        else                state_q <= S_RD_CUR;
                    end else if (ev_valid) begin
                        if (uninit) begin
                            done_q   <= 1'b1;
                            status_q <= EVS_UNINIT;
                        end else if (occ_full) begin
                            done_q   <= 1'b1;
                            status_q <= EVS_FULL;
                        end else begin
                            rec_q   <= ev_data;
                            state_q <= S_WR_REC;
                        end
                    end
                end
                S_WR_REC: if (mem_ready) state_q <= S_WR_OWN;
                S_WR_OWN: if (mem_ready) begin
                    enq_q  <= enq_q + STEP;
                    left_q <= left_q - CNT_W'(1);
                    if (left_q == CNT_W'(1)) begin
                        evt_q   <= 1'b1;
                        state_q <= S_RD_CUR;
                        if (idx_inc == size_q) begin
                            idx_q <= '0;
                            own_q <= ~own_q;
                        end else begin
                            idx_q <= idx_inc;
                        end
                    end else begin
                        done_q   <= 1'b1;
                        status_q <= EVS_OK;
                        state_q  <= S_IDLE;
                    end
                end
                S_RD_CUR: if (mem_ready) begin
                    enq_q   <= seg_base;
                    left_q  <= seg_cnt;
                    err_q   <= 1'b0;
                    state_q <= S_RD_NXT;
                end
                S_RD_NXT: if (mem_ready) begin
                    nxt_q   <= seg_base;
                    state_q <= S_IDLE;
                    if (evt_q) begin
                        done_q   <= 1'b1;
                        status_q <= EVS_OK;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
            if ((cfg_size_we || cfg_base_we) && (new_size != '0) && (new_base != '0))
                pend_q <= 1'b1;
        end
    end

    // Software-programmed registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q  <= '0;
            tbase_q <= '0;
            deq_q   <= '0;
        end else begin
            if (cfg_size_we) size_q  <= cfg_size;
            if (cfg_base_we) tbase_q <= cfg_base;
            if (cfg_deq_we)  deq_q   <= cfg_deq;
        end
    end

    a_r3_first_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_wstrb == 16'hFFFF) |-> (mem_wdata[OWN_BIT] != own_q));
    a_r3_second_owned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_wstrb == 16'hF000) |-> (mem_wdata[OWN_BIT] == own_q));
    a_r4_enq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR_OWN && mem_ready && left_q != CNT_W'(1))
        |=> (enq_q == $past(enq_q) + STEP && left_q == $past(left_q) - CNT_W'(1)));
    a_r6_lap_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WR_OWN && mem_ready && left_q == CNT_W'(1) && idx_inc == size_q)
        |=> (idx_q == '0 && own_q != $past(own_q)));
    a_r2_uninit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && uninit) |=> (!mem_req && ev_done && ev_status == 2'd2));
    a_r9_full_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready && !uninit && occ_full) |=> (!mem_req && ev_done && ev_status == 2'd1));
    a_r12_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && pend_q && idx_q > size_q) |=> (acc_err && !mem_req));
endmodule

// File: tb/evq_producer_bench.sv
module evq_producer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;

    typedef struct packed {
        logic [7:0]  tag;
        logic [15:0] addr;
        logic        own;
        logic        full_after;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{8'h01, 16'h0100, 1'b1, 1'b0},
        '{8'h02, 16'h0110, 1'b1, 1'b0},
        '{8'h03, 16'h0120, 1'b1, 1'b0},
        '{8'h04, 16'h0200, 1'b1, 1'b0},
        '{8'h05, 16'h0210, 1'b1, 1'b0},
        '{8'h06, 16'h0220, 1'b1, 1'b0},
        '{8'h07, 16'h0300, 1'b1, 1'b0},
        '{8'h08, 16'h0310, 1'b1, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_size_we = 0, cfg_base_we = 0, cfg_deq_we = 0;
    logic [15:0] cfg_size = '0;
    logic [31:0] cfg_base = '0, cfg_deq = '0;
    logic ev_valid = 0, ev_ready, ev_done, busy;
    logic [127:0] ev_data = '0;
    logic [1:0] ev_status;
    logic ring_empty, ring_full, ring_uninit, cycle_state, acc_err;
    logic [31:0] enq_ptr, mem_addr;
    logic mem_req, mem_we, mem_ready = 1'b0;
    logic [127:0] mem_wdata, mem_rdata = '0;
    logic [15:0] mem_wstrb;

    int checks = 0, errors = 0, memops = 0, phase_err = 0;
    logic [127:0] mem_arr [0:255];
    logic [31:0] last_full_addr = '1;
    logic last_full_bit = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evq_producer u_evq_producer (
        .clk(clk), .rst_n(rst_n),
        .cfg_size_we(cfg_size_we), .cfg_size(cfg_size),
        .cfg_base_we(cfg_base_we), .cfg_base(cfg_base),
        .cfg_deq_we(cfg_deq_we), .cfg_deq(cfg_deq),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_data(ev_data),
        .ev_done(ev_done), .ev_status(ev_status), .busy(busy),
        .ring_empty(ring_empty), .ring_full(ring_full), .ring_uninit(ring_uninit),
        .enq_ptr(enq_ptr), .cycle_state(cycle_state), .acc_err(acc_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Memory model: one-cycle response, plus a write-order monitor for R3.
    always @(posedge clk) begin
        if (mem_req && !mem_ready) begin
            memops <= memops + 1;
            mem_ready <= 1'b1;
            mem_rdata <= mem_arr[mem_addr[11:4]];
            if (mem_we) begin
                if (mem_wstrb == 16'hF000) begin
                    if (last_full_addr != mem_addr || last_full_bit == mem_wdata[96])
                        phase_err <= phase_err + 1;
                    last_full_addr <= '1;
                end else begin
                    last_full_addr <= mem_addr;
                    last_full_bit  <= mem_wdata[96];
                end
                for (int b = 0; b < 16; b++)
                    if (mem_wstrb[b]) mem_arr[mem_addr[11:4]][b*8 +: 8] = mem_wdata[b*8 +: 8];
            end
        end else begin
            mem_ready <= 1'b0;
        end
    end

    function automatic logic [127:0] make_data(input logic [7:0] tag);
        return {32'h5A5A_0001, 32'h1234_5678, 32'h9ABC_DEF0, 24'h0, tag};
    endfunction

    function automatic logic [127:0] expect_rec(input logic [7:0] tag, input logic own);
        logic [127:0] r;
        r = make_data(tag);
        r[96] = own;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int which, input logic [31:0] val);
        @(negedge clk);
        case (which)
            0: begin cfg_size_we = 1; cfg_size = val[15:0]; end
            1: begin cfg_base_we = 1; cfg_base = val; end
            default: begin cfg_deq_we = 1; cfg_deq = val; end
        endcase
        @(negedge clk);
        cfg_size_we = 0; cfg_base_we = 0; cfg_deq_we = 0;
        while (busy || !ev_ready) @(negedge clk);
    endtask

    task automatic send_event(input logic [7:0] tag, output logic [1:0] st,
                              output bit busy_seen, output bit one_cycle);
        @(negedge clk);
        ev_data = make_data(tag);
        ev_valid = 1'b1;
        while (!ev_ready) @(negedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        busy_seen = busy;
        while (!ev_done) @(negedge clk);
        st = ev_status;
        @(negedge clk);
        one_cycle = !ev_done;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", WD_CYCLES, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] st;
        bit bs, oc;
        int ops0;
        for (int i = 0; i < 256; i++) mem_arr[i] = '0;
        mem_arr[1] = {48'h0, 16'd3, 64'h100};
        mem_arr[2] = {48'h0, 16'd3, 64'h200};
        mem_arr[3] = {48'h0, 16'd3, 64'h300};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cycle_state == 1'b1, "R1", cycle_state, 1);
        chk(enq_ptr == 0, "R1", enq_ptr, 0);
        chk(!busy && !ev_done && ring_uninit, "R1", {busy, ev_done, ring_uninit}, 3'b001);
        // R2 unconfigured rejection
        ops0 = memops;
        send_event(8'hEE, st, bs, oc);
        chk(st == 2'd2, "R2", st, 2);
        chk(memops == ops0, "R2", memops, ops0);
        // R10 size alone does not reload
        cfg_write(0, 3);
        chk(ring_uninit && enq_ptr == 0 && memops == ops0, "R10", enq_ptr, 0);
        cfg_write(1, 32'h10);
        chk(enq_ptr == 32'h100 && !ring_uninit, "R10", enq_ptr, 32'h100);
        cfg_write(2, 32'h100);
        chk(ring_empty && !ring_full, "R7", {ring_empty, ring_full}, 2'b10);
        // Vector walk: R3 R4 R5 R8 R11
        foreach (VECS[i]) begin
            send_event(VECS[i].tag, st, bs, oc);
            chk(st == 2'd0, "R11", st, 0);
            chk(bs && oc, "R11", {bs, oc}, 2'b11);
            chk(mem_arr[VECS[i].addr[11:4]] == expect_rec(VECS[i].tag, VECS[i].own), "R3",
                mem_arr[VECS[i].addr[11:4]], expect_rec(VECS[i].tag, VECS[i].own));
            chk(ring_full == VECS[i].full_after, "R8", ring_full, VECS[i].full_after);
            chk(!ring_empty, "R7", ring_empty, 0);
        end
        chk(enq_ptr == 32'h320, "R4", enq_ptr, 32'h320);
        // R9 full rejection at segment boundary
        ops0 = memops;
        send_event(8'h09, st, bs, oc);
        chk(st == 2'd1 && memops == ops0, "R9", {st, 8'(memops - ops0)}, {2'd1, 8'd0});
        chk(mem_arr[8'h32] == '0, "R9", mem_arr[8'h32], 0);
        cfg_write(2, 32'h110);
        chk(!ring_full, "R8", ring_full, 0);
        send_event(8'h09, st, bs, oc);
        chk(st == 2'd0 && mem_arr[8'h32] == expect_rec(8'h09, 1'b1), "R3", mem_arr[8'h32], expect_rec(8'h09, 1'b1));
        chk(cycle_state == 1'b0, "R6", cycle_state, 0);
        chk(enq_ptr == 32'h100, "R5", enq_ptr, 32'h100);
        chk(ring_full, "R8", ring_full, 1);
        ops0 = memops;
        send_event(8'hAA, st, bs, oc);
        chk(st == 2'd1 && memops == ops0, "R9", st, 1);
        cfg_write(2, 32'h100);
        chk(ring_empty && !ring_full, "R7", {ring_empty, ring_full}, 2'b10);
        send_event(8'h0A, st, bs, oc);
        chk(mem_arr[8'h10] == expect_rec(8'h0A, 1'b0), "R6", mem_arr[8'h10], expect_rec(8'h0A, 1'b0));
        chk(phase_err == 0, "R3", phase_err, 0);
        // Advance to segment index 2, then shrink the table: R12
        for (int t = 8'h0B; t <= 8'h0F; t++) send_event(8'(t), st, bs, oc);
        chk(enq_ptr == 32'h300 && !acc_err, "R5", enq_ptr, 32'h300);
        ops0 = memops;
        cfg_write(0, 1);
        chk(acc_err && enq_ptr == 32'h300, "R12", {acc_err, enq_ptr}, {1'b1, 32'h300});
        chk(memops == ops0, "R12", memops, ops0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule